// File: doc/BRIEF.md
# ALU Operand Bypass Select Unit

This block decides, for each ALU operand of an in-order five-stage pipeline, where the operand value comes from. The execute stage holds two source register indices. The unit compares each of them with the destination index of the instruction one stage ahead, held in the execute/memory register, and with the destination index of the instruction two stages ahead, held in the memory/writeback register. A comparison counts only when that instruction really writes the register file. The result is a 2-bit select for each operand. A small multiplexer then uses the select to pass on the register file value, the execute/memory result or the writeback data.

When both later stages match the same source, the younger result wins, because it is the newer value of that architectural register. Register zero is hard-wired to a constant, so a destination of zero never causes a bypass. The unit has no clock and no state. Each select is a pure function of the current pipeline register fields. Stall generation for load-use cases and branch handling are done elsewhere.

Top module: `operand_bypass`

## Requirements
- R1: When the execute/memory write enable is 1, its destination is nonzero and it equals an operand's source index, that operand's select is 2'b10 and its output value is the execute/memory result.
- R2: When the memory/writeback write enable is 1, its destination is nonzero, it equals an operand's source index and the R1 condition does not hold for that operand, the select is 2'b01 and the output value is the writeback data.
- R3: When both the R1 and the R2 match conditions hold for an operand, the select is 2'b10 and the execute/memory result is passed.
- R4: A destination index of 0 never causes a bypass. A source index of 0 always yields select 2'b00 and the register file value, whatever the write enables are.
- R5: A stage whose write enable is 0 never causes a bypass, even when its destination matches the source index.
- R6: With no qualifying match, the select is 2'b00 and the output value is the operand's register file value. The select value 2'b11 never occurs.
- R7: Operand 0 and operand 1 are evaluated independently. Each gets its own select and value from its own source index.
- R8: The outputs are combinational. They follow a change of any input in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_src_i | input | NUM_OPS x REG_AW | Source register index of each operand in the execute stage |
| idex_rf_i | input | NUM_OPS x DATA_W | Register file value read for each operand |
| exmem_dst_i | input | REG_AW | Destination index in the execute/memory register |
| exmem_wen_i | input | 1 | Register write enable in the execute/memory register |
| exmem_res_i | input | DATA_W | ALU result in the execute/memory register |
| memwb_dst_i | input | REG_AW | Destination index in the memory/writeback register |
| memwb_wen_i | input | 1 | Register write enable in the memory/writeback register |
| memwb_res_i | input | DATA_W | Writeback data in the memory/writeback register |
| op_sel_o | output | NUM_OPS x 2 | Bypass select per operand: 00 register file, 10 execute/memory, 01 writeback |
| op_val_o | output | NUM_OPS x DATA_W | Selected operand value |

## Verification
The bench sets up both later stages so that they match the same source at once. A unit that gives the older stage priority would hand the ALU a stale value there. It writes with destination zero while the source index is also zero. A design that leaves out the zero check would bypass a value where the constant belongs. It raises matches while the write enable is clear, which shows whether the enable gates the compare. It gives the two operands different sources, so that a swapped or shared compare changes the wrong select. A randomized sweep over narrow index ranges drives these collisions often, and checks each result against a reference model written from the requirements.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_MEMWB   = 2'b01,
    SEL_EXMEM   = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import opfwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exmem_dst_i,
  input  logic              exmem_wen_i,
  input  logic [REG_AW-1:0] memwb_dst_i,
  input  logic              memwb_wen_i,
  output byp_sel_e          sel_o
);
  logic ex_hit, wb_hit;

  always_comb begin
    ex_hit = exmem_wen_i && (exmem_dst_i != '0) && (exmem_dst_i == src_i);
    // younger stage wins
    wb_hit = memwb_wen_i && (memwb_dst_i != '0) && (memwb_dst_i == src_i) && !ex_hit;
    if (ex_hit)      sel_o = SEL_EXMEM;
    else if (wb_hit) sel_o = SEL_MEMWB;
    else             sel_o = SEL_REGFILE;
  end

  always_comb begin
    if (!$isunknown({src_i, exmem_dst_i, exmem_wen_i, memwb_dst_i, memwb_wen_i})) begin
      assert_sel_legal_R6: assert (sel_o != 2'b11)
        else $error("illegal select");
      assert_src0_no_fwd_R4: assert (src_i != '0 || sel_o == SEL_REGFILE)
        else $error("bypass on register zero");
      assert_ex_needs_wen_R5: assert (sel_o != SEL_EXMEM || exmem_wen_i)
        else $error("execute/memory bypass without write enable");
      assert_wb_needs_wen_R5: assert (sel_o != SEL_MEMWB || memwb_wen_i)
        else $error("writeback bypass without write enable");
      assert_ex_priority_R3: assert (sel_o != SEL_MEMWB ||
                                     !(exmem_wen_i && exmem_dst_i == src_i))
        else $error("writeback chosen over younger match");
    end
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  byp_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] exmem_i,
  input  logic [DATA_W-1:0] memwb_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EXMEM: val_o = exmem_i;
      SEL_MEMWB: val_o = memwb_i;
      default:   val_o = rf_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({sel_i, rf_i, exmem_i, memwb_i})) begin
      assert_mux_ex_R1: assert (sel_i != SEL_EXMEM || val_o == exmem_i)
        else $error("mux ignored execute/memory select");
      assert_mux_wb_R2: assert (sel_i != SEL_MEMWB || val_o == memwb_i)
        else $error("mux ignored writeback select");
    end
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import opfwd_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_OPS-1:0][REG_AW-1:0] idex_src_i,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] idex_rf_i,
  input  logic [REG_AW-1:0]              exmem_dst_i,
  input  logic                           exmem_wen_i,
  input  logic [DATA_W-1:0]              exmem_res_i,
  input  logic [REG_AW-1:0]              memwb_dst_i,
  input  logic                           memwb_wen_i,
  input  logic [DATA_W-1:0]              memwb_res_i,
  output logic [NUM_OPS-1:0][1:0]        op_sel_o,
  output logic [NUM_OPS-1:0][DATA_W-1:0] op_val_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    byp_sel_e sel;

    fwd_match #(.REG_AW(REG_AW)) u_match (
      .src_i       (idex_src_i[g]),
      .exmem_dst_i (exmem_dst_i),
      .exmem_wen_i (exmem_wen_i),
      .memwb_dst_i (memwb_dst_i),
      .memwb_wen_i (memwb_wen_i),
      .sel_o       (sel)
    );

    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
      .sel_i   (sel),
      .rf_i    (idex_rf_i[g]),
      .exmem_i (exmem_res_i),
      .memwb_i (memwb_res_i),
      .val_o   (op_val_o[g])
    );

    assign op_sel_o[g] = sel;
  end
endmodule

// File: tb/tb_operand_bypass.sv
module tb_operand_bypass;
  localparam int NOPS = 2;
  localparam int AW   = 5;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [NOPS-1:0][AW-1:0] src = '0;
  logic [NOPS-1:0][DW-1:0] rf  = '0;
  logic [AW-1:0] xd = '0;
  logic          xw = 1'b0;
  logic [DW-1:0] xr = '0;
  logic [AW-1:0] wd = '0;
  logic          ww = 1'b0;
  logic [DW-1:0] wr = '0;
  logic [NOPS-1:0][1:0]    sel;
  logic [NOPS-1:0][DW-1:0] val;

  int checks = 0;
  int errors = 0;

  operand_bypass #(.NUM_OPS(NOPS), .REG_AW(AW), .DATA_W(DW)) dut (
    .idex_src_i(src), .idex_rf_i(rf),
    .exmem_dst_i(xd), .exmem_wen_i(xw), .exmem_res_i(xr),
    .memwb_dst_i(wd), .memwb_wen_i(ww), .memwb_res_i(wr),
    .op_sel_o(sel), .op_val_o(val)
  );

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (xw && xd != 0 && xd == s) return 2'b10;
    if (ww && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_val(int k);
    case (ref_sel(src[k]))
      2'b10:   return xr;
      2'b01:   return wr;
      default: return rf[k];
    endcase
  endfunction

  task automatic check_op(string tag, int k, logic [1:0] es, logic [DW-1:0] ev);
    checks++;
    if (sel[k] !== es || val[k] !== ev) begin
      errors++;
      $display("FAIL %s op%0d: sel=%b val=%h expected sel=%b val=%h",
               tag, k, sel[k], val[k], es, ev);
    end
  endtask

  task automatic set_data();
    rf[0] = 32'h1111_0000; rf[1] = 32'h2222_0000;
    xr = 32'hE0E0_0001; wr = 32'hB0B0_0002;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    settle();
    check_op("R6", 0, 2'b00, 32'h0);
    check_op("R6", 1, 2'b00, 32'h0);
  endtask

  task automatic t_ex_fwd();
    set_data();
    src[0] = 5'd7; src[1] = 5'd9; xd = 5'd7; xw = 1; wd = 5'd3; ww = 1;
    settle();
    check_op("R1", 0, 2'b10, xr);
    check_op("R6", 1, 2'b00, rf[1]);
  endtask

  task automatic t_wb_fwd();
    src[0] = 5'd12; src[1] = 5'd31; xd = 5'd4; xw = 1; wd = 5'd31; ww = 1;
    settle();
    check_op("R2", 1, 2'b01, wr);
    check_op("R6", 0, 2'b00, rf[0]);
  endtask

  task automatic t_both();
    src[0] = 5'd5; src[1] = 5'd5; xd = 5'd5; xw = 1; wd = 5'd5; ww = 1;
    settle();
    check_op("R3", 0, 2'b10, xr);
    check_op("R3", 1, 2'b10, xr);
  endtask

  task automatic t_x0();
    src[0] = 5'd0; src[1] = 5'd0; xd = 5'd0; xw = 1; wd = 5'd0; ww = 1;
    settle();
    check_op("R4", 0, 2'b00, rf[0]);
    check_op("R4", 1, 2'b00, rf[1]);
    // x0 in EX/MEM must not mask a valid WB match either
    src[0] = 5'd8; xd = 5'd0; wd = 5'd8;
    settle();
    check_op("R4", 0, 2'b01, wr);
  endtask

  task automatic t_wen_low();
    src[0] = 5'd10; src[1] = 5'd11; xd = 5'd10; xw = 0; wd = 5'd11; ww = 0;
    settle();
    check_op("R5", 0, 2'b00, rf[0]);
    check_op("R5", 1, 2'b00, rf[1]);
    ww = 1; wd = 5'd10;
    settle();
    check_op("R5", 0, 2'b01, wr);
  endtask

  task automatic t_indep();
    src[0] = 5'd20; src[1] = 5'd21; xd = 5'd21; xw = 1; wd = 5'd20; ww = 1;
    settle();
    check_op("R7", 0, 2'b01, wr);
    check_op("R7", 1, 2'b10, xr);
  endtask

  task automatic t_comb();
    @(posedge clk); #1;
    src[0] = 5'd2; xd = 5'd2; xw = 1; xr = 32'hCAFE_0003;
    #1;
    check_op("R8", 0, 2'b10, 32'hCAFE_0003);
    xw = 0;
    #1;
    check_op("R8", 0, 2'b00, rf[0]);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < NOPS; k++) begin
        src[k] = AW'($urandom_range(0, 3));
        rf[k]  = $urandom;
      end
      xd = AW'($urandom_range(0, 3)); xw = 1'($urandom);
      wd = AW'($urandom_range(0, 3)); ww = 1'($urandom);
      xr = $urandom; wr = $urandom;
      settle();
      for (int k = 0; k < NOPS; k++) check_op("R1/R2/R3/R4/R5 rand", k, ref_sel(src[k]), ref_val(k));
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ex_fwd();
    t_wb_fwd();
    t_both();
    t_x0();
    t_wen_low();
    t_indep();
    t_comb();
    t_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule